// File: doc/BRIEF.md
# Rotating Clos Stage Configuration Generator

This block produces the connection maps for the three bufferless stages of a four-stage load-balancing Clos switch: the input module, the central-input module and the central-output module. It keeps a single slot counter that moves forward on each slot strobe. From the per-stage rotation offsets it computes, for every stage input, the stage output that the input is joined to in the current slot. No requests, grants or arbitration are involved. Each map is a fixed modular rotation, so the work per slot is constant whatever the traffic.

The input stage maps port `s` to central module `(s + t) mod CEN_MODS`. The central-input stage maps the link from input module `i` to output `(i + t) mod EDGE_MODS`. The central-output stage rotates the other way and maps input `p` to output module `(p - t) mod EDGE_MODS`. Because all input modules share one rule, a single input-stage map serves every one of them. The block also holds three bufferless crossbars that apply the current maps to data lanes. A switch can use them directly, or they can serve as a reference for the real crossbars.

Top module: `cyclic_clos_cfg`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `slotIdx` is 0 and every map is the identity: input-stage lane `s` holds `s`, and central lanes `i` and `p` hold `i` and `p`.
- R2: At a rising clock edge with `slotTick` high, the slot advances by one. With `slotTick` low, `slotIdx` and all maps keep their values.
- R3: Input-stage map lane `s` (bits `s*CW +: CW` of `imMap`) equals `(s + t) mod CEN_MODS`, where `t` is the number of slot ticks since reset.
- R4: Central-input map lane `i` (bits `i*EW +: EW` of `cimMap`) equals `(i + t) mod EDGE_MODS`.
- R5: Central-output map lane `p` (bits `p*EW +: EW` of `comMap`) equals `(p - t) mod EDGE_MODS`, computed without a negative intermediate. Applying it after the central-input map returns the original module index.
- R6: In every slot, the central-input and central-output maps are permutations. The input-stage map sends its `IM_PORTS` lanes to distinct central modules, which requires `IM_PORTS <= CEN_MODS`.
- R7: `slotIdx` counts from 0 to `PERIOD-1`, where `PERIOD = lcm(CEN_MODS, EDGE_MODS)`, then wraps to 0. On the wrap, every map is back to the identity.
- R8: Each crossbar output lane carries the data of the one input lane mapped to it in the current slot. Input-stage output lanes with no mapped input carry zero. A tick changes the routing only from the next cycle.
- R9: Over `EDGE_MODS` consecutive slots, every central-input and central-output input meets every output exactly once. Over `CEN_MODS` consecutive slots, every input-stage port meets every central module at most once, and exactly once when the ports fill all positions over the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotTick | input | 1 | Advance to the next slot at this edge |
| slotIdx | output | SW | Current slot index modulo PERIOD |
| imMap | output | IM_PORTS*CW | Central module chosen by each input-stage port |
| cimMap | output | EDGE_MODS*EW | Output chosen by each central-input lane |
| comMap | output | EDGE_MODS*EW | Output module chosen by each central-output lane |
| imDataIn | input | IM_PORTS*W | Input-stage data lanes |
| imDataOut | output | CEN_MODS*W | Input-stage crossbar outputs |
| cimDataIn | input | EDGE_MODS*W | Central-input data lanes |
| cimDataOut | output | EDGE_MODS*W | Central-input crossbar outputs |
| comDataIn | input | EDGE_MODS*W | Central-output data lanes |
| comDataOut | output | EDGE_MODS*W | Central-output crossbar outputs |

## Verification
Data can cross the crossbars in the same cycle that a slot tick, including the wrapping tick, updates the maps. The bench drives random data with randomly placed ticks and some long runs of back-to-back ticks. It then checks that each cycle's data follows the map of the slot that was current before the edge. After the edge, the maps and `slotIdx` must show the advanced slot, and after `PERIOD-1` they must show the identity maps of slot 0.

// File: rtl/cyc_clos_pkg.sv
package cyc_clos_pkg;

  typedef struct packed {
    logic step;
    logic wrap;
  } slotStrobe_t;

  function automatic int gcdOf(int a, int b);
    int x;
    int y;
    int r;
    x = a;
    y = b;
    while (y != 0) begin
      r = x % y;
      x = y;
      y = r;
    end
    return x;
  endfunction

  function automatic int lcmOf(int a, int b);
    return (a / gcdOf(a, b)) * b;
  endfunction

  function automatic int widthOf(int v);
    return (v <= 2) ? 1 : $clog2(v);
  endfunction

endpackage

// File: rtl/slot_ctrl.sv
module slot_ctrl
  import cyc_clos_pkg::*;
#(
  parameter int PERIOD = 12,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          slotTick,
  output logic [SW-1:0] slotIdx,
  output slotStrobe_t   strobe
);

  localparam logic [SW-1:0] LAST = SW'(PERIOD - 1);

  logic atLast;
  assign atLast = (slotIdx == LAST);

  always_ff @(posedge clk) begin
    if (!rstN) slotIdx <= '0;
    else if (slotTick) slotIdx <= atLast ? '0 : slotIdx + 1'b1;
  end

  always_comb begin
    strobe.step = slotTick;
    strobe.wrap = slotTick && atLast;
  end

  assert_slot_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    int'(slotIdx) < PERIOD);

  assert_slot_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !slotTick |=> $stable(slotIdx));

  assert_slot_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    slotTick |=> int'(slotIdx) == ((int'($past(slotIdx)) + 1) % PERIOD));

endmodule

// File: rtl/cfg_datapath.sv
module cfg_datapath
  import cyc_clos_pkg::*;
#(
  parameter int IM_PORTS = 2,
  parameter int CEN_MODS = 3,
  parameter int EDGE_MODS = 4,
  parameter int CW = 2,
  parameter int EW = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  slotStrobe_t               strobe,
  output logic [IM_PORTS*CW-1:0]    imMap,
  output logic [EDGE_MODS*EW-1:0]   cimMap,
  output logic [EDGE_MODS*EW-1:0]   comMap
);

  localparam logic [CW-1:0] IM_LAST = CW'(CEN_MODS - 1);
  localparam logic [EW-1:0] EDGE_LAST = EW'(EDGE_MODS - 1);

  logic [CW-1:0] imOff;
  logic [EW-1:0] cenOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      imOff  <= '0;
      cenOff <= '0;
    end else if (strobe.step) begin
      imOff  <= (imOff == IM_LAST) ? '0 : imOff + 1'b1;
      cenOff <= (cenOff == EDGE_LAST) ? '0 : cenOff + 1'b1;
    end
  end

  for (genvar s = 0; s < IM_PORTS; s++) begin : g_im
    logic [CW:0] sum;
    always_comb begin
      sum = {1'b0, imOff} + (CW+1)'(s);
      if (int'(sum) >= CEN_MODS) sum = sum - (CW+1)'(CEN_MODS);
      imMap[s*CW +: CW] = sum[CW-1:0];
    end
  end

  for (genvar i = 0; i < EDGE_MODS; i++) begin : g_cen
    logic [EW:0] fwd;
    logic [EW:0] rev;
    always_comb begin
      fwd = {1'b0, cenOff} + (EW+1)'(i);
      if (int'(fwd) >= EDGE_MODS) fwd = fwd - (EW+1)'(EDGE_MODS);
      // reverse rotation: add the modulus first so nothing goes negative
      rev = (EW+1)'(i) + (EW+1)'(EDGE_MODS) - {1'b0, cenOff};
      if (int'(rev) >= EDGE_MODS) rev = rev - (EW+1)'(EDGE_MODS);
      cimMap[i*EW +: EW] = fwd[EW-1:0];
      comMap[i*EW +: EW] = rev[EW-1:0];
    end
  end

  // checking logic: column usage and round-trip through both central maps
  logic [EDGE_MODS-1:0] cimUsed;
  logic [EDGE_MODS-1:0] comUsed;
  logic [CEN_MODS-1:0]  imUsed;
  logic                 roundTripOk;

  always_comb begin
    cimUsed = '0;
    comUsed = '0;
    imUsed = '0;
    roundTripOk = 1'b1;
    for (int i = 0; i < EDGE_MODS; i++) begin
      if (int'(cimMap[i*EW +: EW]) < EDGE_MODS) cimUsed[cimMap[i*EW +: EW]] = 1'b1;
      if (int'(comMap[i*EW +: EW]) < EDGE_MODS) comUsed[comMap[i*EW +: EW]] = 1'b1;
      if (int'(cimMap[i*EW +: EW]) < EDGE_MODS) begin
        if (int'(comMap[int'(cimMap[i*EW +: EW])*EW +: EW]) != i) roundTripOk = 1'b0;
      end else begin
        roundTripOk = 1'b0;
      end
    end
    for (int s = 0; s < IM_PORTS; s++) begin
      if (int'(imMap[s*CW +: CW]) < CEN_MODS) imUsed[imMap[s*CW +: CW]] = 1'b1;
    end
  end

  assert_cim_perm_R6: assert property (@(posedge clk) disable iff (!rstN)
    $countones(cimUsed) == EDGE_MODS);

  assert_com_perm_R6: assert property (@(posedge clk) disable iff (!rstN)
    $countones(comUsed) == EDGE_MODS);

  assert_im_distinct_R6: assert property (@(posedge clk) disable iff (!rstN)
    $countones(imUsed) == IM_PORTS);

  assert_round_trip_R5: assert property (@(posedge clk) disable iff (!rstN)
    roundTripOk);

  assert_wrap_align_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrap |=> (imOff == '0) && (cenOff == '0));

  assert_off_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.step |=> $stable(imOff) && $stable(cenOff));

endmodule

// File: rtl/map_xbar.sv
module map_xbar #(
  parameter int IN_N = 4,
  parameter int OUT_N = 4,
  parameter int SEL_W = 2,
  parameter int W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [IN_N*SEL_W-1:0]  selMap,
  input  logic [IN_N*W-1:0]      dataIn,
  output logic [OUT_N*W-1:0]     dataOut
);

  logic [OUT_N-1:0][IN_N-1:0] hitMat;

  always_comb begin
    dataOut = '0;
    hitMat = '0;
    for (int o = 0; o < OUT_N; o++) begin
      for (int i = 0; i < IN_N; i++) begin
        if (int'(selMap[i*SEL_W +: SEL_W]) == o) begin
          hitMat[o][i] = 1'b1;
          dataOut[o*W +: W] = dataOut[o*W +: W] | dataIn[i*W +: W];
        end
      end
    end
  end

  for (genvar o = 0; o < OUT_N; o++) begin : g_chk
    assert_one_source_R8: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(hitMat[o]));
  end

endmodule

// File: rtl/cyclic_clos_cfg.sv
module cyclic_clos_cfg
  import cyc_clos_pkg::*;
#(
  parameter int IM_PORTS = 2,
  parameter int CEN_MODS = 3,
  parameter int EDGE_MODS = 4,
  parameter int W = 8,
  localparam int PERIOD = lcmOf(CEN_MODS, EDGE_MODS),
  localparam int SW = widthOf(PERIOD),
  localparam int CW = widthOf(CEN_MODS),
  localparam int EW = widthOf(EDGE_MODS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      slotTick,
  output logic [SW-1:0]             slotIdx,
  output logic [IM_PORTS*CW-1:0]    imMap,
  output logic [EDGE_MODS*EW-1:0]   cimMap,
  output logic [EDGE_MODS*EW-1:0]   comMap,
  input  logic [IM_PORTS*W-1:0]     imDataIn,
  output logic [CEN_MODS*W-1:0]     imDataOut,
  input  logic [EDGE_MODS*W-1:0]    cimDataIn,
  output logic [EDGE_MODS*W-1:0]    cimDataOut,
  input  logic [EDGE_MODS*W-1:0]    comDataIn,
  output logic [EDGE_MODS*W-1:0]    comDataOut
);

  slotStrobe_t strobe;

  slot_ctrl #(.PERIOD(PERIOD), .SW(SW)) u_ctrl (
    .clk(clk), .rstN(rstN), .slotTick(slotTick),
    .slotIdx(slotIdx), .strobe(strobe)
  );

  cfg_datapath #(
    .IM_PORTS(IM_PORTS), .CEN_MODS(CEN_MODS), .EDGE_MODS(EDGE_MODS),
    .CW(CW), .EW(EW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .imMap(imMap), .cimMap(cimMap), .comMap(comMap)
  );

  map_xbar #(.IN_N(IM_PORTS), .OUT_N(CEN_MODS), .SEL_W(CW), .W(W)) u_imXbar (
    .clk(clk), .rstN(rstN), .selMap(imMap), .dataIn(imDataIn), .dataOut(imDataOut)
  );

  map_xbar #(.IN_N(EDGE_MODS), .OUT_N(EDGE_MODS), .SEL_W(EW), .W(W)) u_cimXbar (
    .clk(clk), .rstN(rstN), .selMap(cimMap), .dataIn(cimDataIn), .dataOut(cimDataOut)
  );

  map_xbar #(.IN_N(EDGE_MODS), .OUT_N(EDGE_MODS), .SEL_W(EW), .W(W)) u_comXbar (
    .clk(clk), .rstN(rstN), .selMap(comMap), .dataIn(comDataIn), .dataOut(comDataOut)
  );

  assert_wrap_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrap |=> slotIdx == '0);

endmodule

// File: tb/sim_cyclic_clos_cfg.sv
module sim_cyclic_clos_cfg;
  import cyc_clos_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;
  localparam int CM = 3;
  localparam int EM = 4;
  localparam int W = 8;
  localparam int L = lcmOf(CM, EM);
  localparam int SW = widthOf(L);
  localparam int CW = widthOf(CM);
  localparam int EW = widthOf(EM);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slotTick = 1'b0;
  logic [SW-1:0] slotIdx;
  logic [NP*CW-1:0] imMap;
  logic [EM*EW-1:0] cimMap, comMap;
  logic [NP*W-1:0] imDataIn = '0;
  logic [CM*W-1:0] imDataOut;
  logic [EM*W-1:0] cimDataIn = '0, cimDataOut, comDataIn = '0, comDataOut;

  int checks = 0;
  int failures = 0;
  int tModel = 0;
  bit finished = 0;
  int seenIm[NP][CM];
  int seenCim[EM][EM];
  int seenCom[EM][EM];

  always #(CLK_PERIOD/2) clk = ~clk;

  cyclic_clos_cfg #(.IM_PORTS(NP), .CEN_MODS(CM), .EDGE_MODS(EM), .W(W)) u0 (
    .clk(clk), .rstN(rstN), .slotTick(slotTick), .slotIdx(slotIdx),
    .imMap(imMap), .cimMap(cimMap), .comMap(comMap),
    .imDataIn(imDataIn), .imDataOut(imDataOut),
    .cimDataIn(cimDataIn), .cimDataOut(cimDataOut),
    .comDataIn(comDataIn), .comDataOut(comDataOut)
  );

  function automatic int expIm(int s, int t); return (s + t) % CM; endfunction
  function automatic int expCim(int i, int t); return (i + t) % EM; endfunction
  function automatic int expCom(int p, int t); return (p + EM - (t % EM)) % EM; endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic verifyAll(int t);
    int used;
    for (int s = 0; s < NP; s++)
      chk(int'(imMap[s*CW +: CW]) == expIm(s, t), "R3 im map", int'(imMap[s*CW +: CW]), expIm(s, t));
    for (int i = 0; i < EM; i++) begin
      chk(int'(cimMap[i*EW +: EW]) == expCim(i, t), "R4 cim map", int'(cimMap[i*EW +: EW]), expCim(i, t));
      chk(int'(comMap[i*EW +: EW]) == expCom(i, t), "R5 com map", int'(comMap[i*EW +: EW]), expCom(i, t));
    end
    used = 0;
    for (int i = 0; i < EM; i++) used |= 1 << int'(cimMap[i*EW +: EW]);
    chk(used == (1 << EM) - 1, "R6 cim permutation", used, (1 << EM) - 1);
    used = 0;
    for (int i = 0; i < EM; i++) used |= 1 << int'(comMap[i*EW +: EW]);
    chk(used == (1 << EM) - 1, "R6 com permutation", used, (1 << EM) - 1);
    used = 0;
    for (int s = 0; s < NP; s++) used |= 1 << int'(imMap[s*CW +: CW]);
    chk($countones(used) == NP, "R6 im distinct", $countones(used), NP);
    for (int o = 0; o < CM; o++) begin
      int e = 0;
      for (int s = 0; s < NP; s++) if (expIm(s, t) == o) e = int'(imDataIn[s*W +: W]);
      chk(int'(imDataOut[o*W +: W]) == e, "R8 im data", int'(imDataOut[o*W +: W]), e);
    end
    for (int o = 0; o < EM; o++) begin
      int ec = int'(cimDataIn[((o + EM - (t % EM)) % EM)*W +: W]);
      int eo = int'(comDataIn[((o + t) % EM)*W +: W]);
      chk(int'(cimDataOut[o*W +: W]) == ec, "R8 cim data", int'(cimDataOut[o*W +: W]), ec);
      chk(int'(comDataOut[o*W +: W]) == eo, "R8 com data", int'(comDataOut[o*W +: W]), eo);
    end
  endtask

  task automatic cycle(bit tick, bit record);
    @(negedge clk);
    slotTick = tick;
    imDataIn = NP*W'($urandom());
    cimDataIn = {$urandom(), $urandom()};
    comDataIn = {$urandom(), $urandom()};
    #1;
    chk(int'(slotIdx) == tModel, "R2 R7 slot index", int'(slotIdx), tModel);
    verifyAll(tModel);
    if (record) begin
      if (tModel < CM) for (int s = 0; s < NP; s++) seenIm[s][int'(imMap[s*CW +: CW])]++;
      if (tModel < EM) for (int i = 0; i < EM; i++) begin
        seenCim[i][int'(cimMap[i*EW +: EW])]++;
        seenCom[i][int'(comMap[i*EW +: EW])]++;
      end
    end
    @(posedge clk);
    if (tick) tModel = (tModel + 1) % L;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    foreach (seenIm[a, b]) seenIm[a][b] = 0;
    foreach (seenCim[a, b]) seenCim[a][b] = 0;
    foreach (seenCom[a, b]) seenCom[a][b] = 0;
    // R1: reset state, tick held high during reset must have no effect
    slotTick = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(slotIdx == '0, "R1 reset slot", int'(slotIdx), 0);
    for (int i = 0; i < EM; i++)
      chk(int'(cimMap[i*EW +: EW]) == i && int'(comMap[i*EW +: EW]) == i, "R1 identity maps",
          int'(cimMap[i*EW +: EW]), i);
    for (int s = 0; s < NP; s++)
      chk(int'(imMap[s*CW +: CW]) == s, "R1 identity im map", int'(imMap[s*CW +: CW]), s);
    slotTick = 1'b0;
    rstN = 1'b1;
    // R9 and R7: one full period of back-to-back ticks, then wrap
    for (int n = 0; n < L; n++) cycle(1'b1, 1'b1);
    chk(tModel == 0, "R7 model wrapped", tModel, 0);
    cycle(1'b0, 1'b0);
    for (int i = 0; i < EM; i++)
      for (int o = 0; o < EM; o++) begin
        chk(seenCim[i][o] == 1, "R9 cim coverage", seenCim[i][o], 1);
        chk(seenCom[i][o] == 1, "R9 com coverage", seenCom[i][o], 1);
      end
    for (int s = 0; s < NP; s++)
      for (int o = 0; o < CM; o++)
        chk(seenIm[s][o] == 1, "R9 im coverage", seenIm[s][o], 1);
    // R2: long hold with no ticks
    for (int n = 0; n < 5; n++) cycle(1'b0, 1'b0);
    // mixed random ticks, several wraps
    for (int n = 0; n < 400; n++) cycle(1'(($urandom() % 3) != 0), 1'b0);
    // mid-run reset returns to identity (R1)
    @(negedge clk);
    rstN = 1'b0;
    slotTick = 1'b0;
    @(posedge clk);
    tModel = 0;
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(slotIdx == '0, "R1 reset again", int'(slotIdx), 0);
    for (int n = 0; n < 3 * L; n++) cycle(1'b1, 1'b0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule